// File: doc/BRIEF.md
# SMBus Host Block Data Buffer

This block holds the bytes of an SMBus or I2C block transfer between the host's register port and its transaction engine. When the buffered mode is enabled, software loads or unloads a whole block through one data register whose internal index advances after every access, while the engine streams the same storage from its own pointer. The byte count of an SMBus block transfer lives in the first data register. For an SMBus block read, the engine's first received byte lands there and is range checked.

When the buffered mode is off, the data register is a single holding byte. Each byte the engine sends or receives raises a byte-done flag, and the engine is held until software clears that flag by writing a one to it. The block also forms the address and command bytes the engine sends. For an I2C block read, the command comes from the second data register and the direction bit is forced to zero. A last-byte control bit asks for a NACK on the final byte of a read.

Top module: `smb_blkbuf`

## Requirements
- R1: After reset the status, control, auxiliary and first data registers read 0x00, and eng_go and eng_hold are low.
- R2: Any read of the control register (address 1) returns the buffer index to entry 0, so the next block data access (address 6) uses entry 0.
- R3: In buffered mode, successive block data writes fill consecutive entries and successive block data reads return them in the same order. Engine transmit pops after a start read consecutive entries from entry 0.
- R4: The index stops at the buffer depth. A write beyond the last entry is dropped without changing any entry, and a read there returns 0x00.
- R5: On an SMBus block read (control kind field bits 1:0 = 1, address bit 0 = 1), the first received byte is stored in the first data register (address 4). Exactly that many following bytes are stored from entry 0, and any further bytes are dropped.
- R6: A received count of 0 or of more than the buffer depth sets status bit 3. Writing 1 to that bit clears it. A count of 0 stores no data.
- R7: With auxiliary bit 1 cleared, block data accesses use a single holding byte and leave the buffer unchanged. Each byte the engine sends or receives (apart from the count) sets status bit 7 and raises eng_hold.
- R8: Writing 1 to status bit 7 clears it and drops eng_hold. Writing 0 there has no effect.
- R9: For control kind 2 (I2C block), eng_addr_byte carries bit 0 as 0. When address bit 0 is 1, eng_cmd_byte is taken from the second data register (address 5). In every other case eng_cmd_byte is the command register (address 2) and eng_addr_byte is the address register (address 3).
- R10: eng_nack_last is high exactly when control bit 2 (last byte) and address bit 0 (read) are both set.
- R11: Writing control bit 6 pulses eng_go for one cycle, one cycle after the write. The bit is not stored and reads back as 0.
- R12: Auxiliary register (address 7) bit 1 selects the buffered mode and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; drives the read side effects |
| reg_addr | input | 3 | Register select: 0 status, 1 control, 2 command, 3 address, 4 data0, 5 data1, 6 block data, 7 auxiliary |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for the selected register (combinational) |
| eng_go | output | 1 | One-cycle start request to the engine |
| eng_is_read | output | 1 | Direction of the transfer, 1 for read |
| eng_addr_byte | output | DW | Address byte for the engine to send |
| eng_cmd_byte | output | DW | Command byte for the engine to send |
| eng_nack_last | output | 1 | NACK the final received byte |
| eng_len | output | DW | Current byte count in data0 |
| eng_tx_pop | input | 1 | Engine takes the next byte to send |
| eng_tx_byte | output | DW | Byte offered to the engine |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | DW | Received byte |
| eng_hold | output | 1 | Engine must stall until byte-done is cleared |

## Verification
The bench builds the block with its default depth of 32 entries of 8 bits. That depth is small enough to fill the buffer completely and then issue one extra write and one extra read at the saturated index. It also allows counts of 0, 1 and 33 to be sent to exercise both sides of the count check. One count of 3 is followed by a fourth byte, which shows that the buffer stops storing at the count while an entry written earlier keeps its value. The byte-mode tests use the same storage afterwards to confirm that the holding byte path never writes the buffer.

// File: rtl/smb_blkbuf_pkg.sv
package smb_blkbuf_pkg;

  typedef enum logic [2:0] {
    RA_STATUS = 3'd0,
    RA_CTRL   = 3'd1,
    RA_CMD    = 3'd2,
    RA_ADDR   = 3'd3,
    RA_DATA0  = 3'd4,
    RA_DATA1  = 3'd5,
    RA_BLK    = 3'd6,
    RA_AUX    = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    XK_OTHER     = 2'd0,
    XK_SMB_BLOCK = 2'd1,
    XK_I2C_BLOCK = 2'd2,
    XK_RSVD      = 2'd3
  } xfer_kind_e;

  localparam int ST_DONE_BIT   = 7;
  localparam int ST_CNTERR_BIT = 3;
  localparam int CT_LAST_BIT   = 2;
  localparam int CT_START_BIT  = 6;
  localparam int AUX_BUF_BIT   = 1;

endpackage

// File: rtl/smb_blkbuf_ptr.sv
module smb_blkbuf_ptr #(
  parameter int DEPTH = 32,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] idx,
  output logic          at_end
);

  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_d;
  logic          idx_en;

  assign at_end = (idx_q == IW'(DEPTH));
  assign idx    = idx_q;

  // next state: clear wins, advance saturates at DEPTH
  always_comb begin
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (clr) begin
      idx_d  = '0;
      idx_en = 1'b1;
    end else if (adv && !at_end) begin
      idx_d  = idx_q + IW'(1);
      idx_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/smb_blkbuf_store.sv
module smb_blkbuf_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] row [DEPTH];

  // one clock-enabled byte register per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic row_en;
    assign row_en = we && (waddr == IW'(g));
    always_ff @(posedge clk) begin
      if (row_en) begin
        row[g] <= wdata;
      end
    end
  end

  // an index at DEPTH (saturated) reads as zero
  assign rdata_a = (raddr_a < IW'(DEPTH)) ? row[raddr_a[AW-1:0]] : '0;
  assign rdata_b = (raddr_b < IW'(DEPTH)) ? row[raddr_b[AW-1:0]] : '0;

endmodule

// File: rtl/smb_blkbuf_regs.sv
module smb_blkbuf_regs
  import smb_blkbuf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] blk_rdata,
  input  logic          eng_cnt_we,
  input  logic [DW-1:0] eng_cnt,
  input  logic          eng_hold_we,
  input  logic [DW-1:0] eng_hold_data,
  input  logic          done_set,
  input  logic          err_set,
  output logic [DW-1:0] reg_rdata,
  output logic          start_wr,
  output logic          ctrl_rd,
  output logic          blk_wr,
  output logic          blk_rd,
  output logic [1:0]    ctrl_kind,
  output logic          ctrl_last,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] data0_q,
  output logic [DW-1:0] data1_q,
  output logic [DW-1:0] hold_q,
  output logic          buf_en,
  output logic          byte_done,
  output logic          cnt_err
);

  logic wr_status, wr_ctrl, wr_cmd, wr_addr, wr_d0, wr_d1, wr_aux;

  assign wr_status = reg_wr && (reg_addr == RA_STATUS);
  assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
  assign wr_cmd    = reg_wr && (reg_addr == RA_CMD);
  assign wr_addr   = reg_wr && (reg_addr == RA_ADDR);
  assign wr_d0     = reg_wr && (reg_addr == RA_DATA0);
  assign wr_d1     = reg_wr && (reg_addr == RA_DATA1);
  assign wr_aux    = reg_wr && (reg_addr == RA_AUX);
  assign blk_wr    = reg_wr && (reg_addr == RA_BLK);
  assign blk_rd    = reg_rd && (reg_addr == RA_BLK);
  assign ctrl_rd   = reg_rd && (reg_addr == RA_CTRL);
  assign start_wr  = wr_ctrl && reg_wdata[CT_START_BIT];

  // next-state values
  logic          done_d, err_d;
  logic [DW-1:0] data0_d, hold_d;
  logic          data0_en, hold_en;

  always_comb begin
    done_d = byte_done;
    if (done_set) begin
      done_d = 1'b1;
    end else if (wr_status && reg_wdata[ST_DONE_BIT]) begin
      done_d = 1'b0;
    end
    err_d = cnt_err;
    if (err_set) begin
      err_d = 1'b1;
    end else if (wr_status && reg_wdata[ST_CNTERR_BIT]) begin
      err_d = 1'b0;
    end
    data0_en = eng_cnt_we || wr_d0;
    data0_d  = eng_cnt_we ? eng_cnt : reg_wdata;
    hold_en  = eng_hold_we || (blk_wr && !buf_en);
    hold_d   = eng_hold_we ? eng_hold_data : reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_done <= 1'b0;
      cnt_err   <= 1'b0;
    end else begin
      byte_done <= done_d;
      cnt_err   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_kind <= 2'd0;
      ctrl_last <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_kind <= reg_wdata[1:0];
      ctrl_last <= reg_wdata[CT_LAST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (wr_cmd) begin
      cmd_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (wr_addr) begin
      addr_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data0_q <= '0;
    end else if (data0_en) begin
      data0_q <= data0_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data1_q <= '0;
    end else if (wr_d1) begin
      data1_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_en <= 1'b0;
    end else if (wr_aux) begin
      buf_en <= reg_wdata[AUX_BUF_BIT];
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_STATUS: begin
        reg_rdata[ST_DONE_BIT]   = byte_done;
        reg_rdata[ST_CNTERR_BIT] = cnt_err;
      end
      RA_CTRL: begin
        reg_rdata[1:0]         = ctrl_kind;
        reg_rdata[CT_LAST_BIT] = ctrl_last;
      end
      RA_CMD:   reg_rdata = cmd_q;
      RA_ADDR:  reg_rdata = addr_q;
      RA_DATA0: reg_rdata = data0_q;
      RA_DATA1: reg_rdata = data1_q;
      RA_BLK:   reg_rdata = buf_en ? blk_rdata : hold_q;
      RA_AUX:   reg_rdata[AUX_BUF_BIT] = buf_en;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf
  import smb_blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          eng_go,
  output logic          eng_is_read,
  output logic [DW-1:0] eng_addr_byte,
  output logic [DW-1:0] eng_cmd_byte,
  output logic          eng_nack_last,
  output logic [DW-1:0] eng_len,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_byte,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_byte,
  output logic          eng_hold
);

  localparam int IW = $clog2(DEPTH + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  // register file
  logic [DW-1:0] blk_rdata, data0_q, data1_q, cmd_q, addr_q, hold_q;
  logic          start_wr, ctrl_rd, blk_wr, blk_rd;
  logic [1:0]    ctrl_kind;
  logic          ctrl_last, buf_en, byte_done, cnt_err;
  logic          cnt_take, data_push, err_set, done_set, hold_we;

  smb_blkbuf_regs #(.DW(DW)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .blk_rdata     (blk_rdata),
    .eng_cnt_we    (cnt_take),
    .eng_cnt       (eng_rx_byte),
    .eng_hold_we   (hold_we),
    .eng_hold_data (eng_rx_byte),
    .done_set      (done_set),
    .err_set       (err_set),
    .reg_rdata     (reg_rdata),
    .start_wr      (start_wr),
    .ctrl_rd       (ctrl_rd),
    .blk_wr        (blk_wr),
    .blk_rd        (blk_rd),
    .ctrl_kind     (ctrl_kind),
    .ctrl_last     (ctrl_last),
    .cmd_q         (cmd_q),
    .addr_q        (addr_q),
    .data0_q       (data0_q),
    .data1_q       (data1_q),
    .hold_q        (hold_q),
    .buf_en        (buf_en),
    .byte_done     (byte_done),
    .cnt_err       (cnt_err)
  );

  // software-side and engine-side pointers
  logic [IW-1:0] sidx, eidx;
  logic          sidx_end, eidx_end, sw_adv, eng_adv;

  smb_blkbuf_ptr #(.DEPTH(DEPTH), .IW(IW)) u_sw_ptr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (ctrl_rd),
    .adv    (sw_adv),
    .idx    (sidx),
    .at_end (sidx_end)
  );

  smb_blkbuf_ptr #(.DEPTH(DEPTH), .IW(IW)) u_eng_ptr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (start_wr),
    .adv    (eng_adv),
    .idx    (eidx),
    .at_end (eidx_end)
  );

  // engine receive bookkeeping: first byte of an SMBus block read is the count
  logic need_cnt_q, need_cnt_d;
  logic below_cnt, eng_mem_we, sw_mem_we;

  assign cnt_take  = eng_rx_push && need_cnt_q;
  assign data_push = eng_rx_push && !need_cnt_q;
  assign err_set   = cnt_take && ((eng_rx_byte == '0) || (eng_rx_byte > DW'(DEPTH)));
  assign below_cnt = (ctrl_kind == XK_SMB_BLOCK) ? (DW'(eidx) < data0_q) : 1'b1;

  assign eng_mem_we = data_push && buf_en && below_cnt && !eidx_end;
  assign sw_mem_we  = blk_wr && buf_en && !sidx_end;
  assign eng_adv    = eng_mem_we || (eng_tx_pop && buf_en);
  assign sw_adv     = (blk_wr || blk_rd) && buf_en;
  assign hold_we    = data_push && !buf_en;
  assign done_set   = (data_push || eng_tx_pop) && !buf_en;

  always_comb begin
    need_cnt_d = need_cnt_q;
    if (start_wr) begin
      need_cnt_d = (reg_wdata[1:0] == XK_SMB_BLOCK) && addr_q[0];
    end else if (cnt_take) begin
      need_cnt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      need_cnt_q <= 1'b0;
    end else begin
      need_cnt_q <= need_cnt_d;
    end
  end

  // shared storage: engine write has priority over a same-cycle software write
  logic          mem_we;
  logic [IW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata, eng_rdata;

  assign mem_we    = eng_mem_we || sw_mem_we;
  assign mem_waddr = eng_mem_we ? eidx : sidx;
  assign mem_wdata = eng_mem_we ? eng_rx_byte : reg_wdata;

  smb_blkbuf_store #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_store (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr_a (sidx),
    .rdata_a (blk_rdata),
    .raddr_b (eidx),
    .rdata_b (eng_rdata)
  );

  // start pulse
  logic go_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      go_q <= 1'b0;
    end else begin
      go_q <= start_wr;
    end
  end

  // engine-facing outputs
  logic i2c_kind;
  assign i2c_kind      = (ctrl_kind == XK_I2C_BLOCK);
  assign eng_go        = go_q;
  assign eng_is_read   = addr_q[0];
  assign eng_addr_byte = i2c_kind ? {addr_q[DW-1:1], 1'b0} : addr_q;
  assign eng_cmd_byte  = (i2c_kind && addr_q[0]) ? data1_q : cmd_q;
  assign eng_nack_last = ctrl_last && addr_q[0];
  assign eng_len       = data0_q;
  assign eng_tx_byte   = buf_en ? eng_rdata : hold_q;
  assign eng_hold      = !buf_en && byte_done;

endmodule

// File: rtl/smb_blkbuf_chk.sv
module smb_blkbuf_chk
  import smb_blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          eng_tx_pop,
  input logic          eng_rx_push,
  input logic          eng_go,
  input logic          eng_hold,
  input logic [DW-1:0] eng_addr_byte,
  input logic          buf_en,
  input logic [1:0]    ctrl_kind,
  input logic [IW-1:0] sidx
);

  AST_GO_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> $past(reg_wr && (reg_addr == RA_CTRL) && reg_wdata[CT_START_BIT])); // R11

  AST_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_pop && !buf_en && !(reg_wr && reg_addr == RA_AUX)) |=> eng_hold); // R7

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == RA_STATUS) && reg_wdata[ST_DONE_BIT] && !eng_tx_pop && !eng_rx_push)
      |=> !eng_hold); // R8

  AST_CTRL_READ_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == RA_CTRL)) |=> (sidx == '0)); // R2

  AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sidx <= IW'(DEPTH)); // R4

  AST_I2C_DIR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_kind == XK_I2C_BLOCK) |-> (eng_addr_byte[0] == 1'b0)); // R9

endmodule

bind smb_blkbuf smb_blkbuf_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_s),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .eng_tx_pop    (eng_tx_pop),
  .eng_rx_push   (eng_rx_push),
  .eng_go        (eng_go),
  .eng_hold      (eng_hold),
  .eng_addr_byte (eng_addr_byte),
  .buf_en        (buf_en),
  .ctrl_kind     (ctrl_kind),
  .sidx          (sidx)
);

// File: tb/test_smb_blkbuf.sv
`timescale 1ns/1ps
module test_smb_blkbuf;

  logic       clk;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       eng_go, eng_is_read, eng_nack_last, eng_hold;
  logic [7:0] eng_addr_byte, eng_cmd_byte, eng_len, eng_tx_byte, eng_rx_byte;
  logic       eng_tx_pop, eng_rx_push;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] v;

  smb_blkbuf i_smb_blkbuf (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_go(eng_go), .eng_is_read(eng_is_read), .eng_addr_byte(eng_addr_byte),
    .eng_cmd_byte(eng_cmd_byte), .eng_nack_last(eng_nack_last), .eng_len(eng_len),
    .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte), .eng_rx_push(eng_rx_push),
    .eng_rx_byte(eng_rx_byte), .eng_hold(eng_hold)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [2:0] A_ST = 3'd0, A_CT = 3'd1, A_CM = 3'd2, A_AD = 3'd3,
                         A_D0 = 3'd4, A_D1 = 3'd5, A_BK = 3'd6, A_AX = 3'd7;

  // {req[3:0], is_read, addr[2:0], wdata[7:0], expect[7:0]}
  localparam int NV = 22;
  localparam logic [23:0] VEC [NV] = '{
    {4'd12, 1'b0, A_AX, 8'h02, 8'h00},
    {4'd12, 1'b1, A_AX, 8'h00, 8'h02},  // R12 aux bit reads back
    {4'd3,  1'b0, A_BK, 8'h11, 8'h00},
    {4'd3,  1'b0, A_BK, 8'h22, 8'h00},
    {4'd3,  1'b0, A_BK, 8'h33, 8'h00},
    {4'd2,  1'b1, A_CT, 8'h00, 8'h00},  // R2 rewind
    {4'd3,  1'b1, A_BK, 8'h00, 8'h11},  // R3 consecutive entries
    {4'd3,  1'b1, A_BK, 8'h00, 8'h22},
    {4'd3,  1'b1, A_BK, 8'h00, 8'h33},
    {4'd2,  1'b1, A_CT, 8'h00, 8'h00},
    {4'd2,  1'b0, A_BK, 8'h44, 8'h00},
    {4'd2,  1'b1, A_CT, 8'h00, 8'h00},
    {4'd2,  1'b1, A_BK, 8'h00, 8'h44},  // R2 write went to entry 0
    {4'd2,  1'b1, A_BK, 8'h00, 8'h22},
    {4'd9,  1'b0, A_D0, 8'h05, 8'h00},
    {4'd9,  1'b1, A_D0, 8'h00, 8'h05},
    {4'd9,  1'b0, A_D1, 8'hA5, 8'h00},
    {4'd9,  1'b1, A_D1, 8'h00, 8'hA5},
    {4'd9,  1'b0, A_CM, 8'h3C, 8'h00},
    {4'd9,  1'b1, A_CM, 8'h00, 8'h3C},
    {4'd9,  1'b0, A_AD, 8'h51, 8'h00},
    {4'd9,  1'b1, A_AD, 8'h00, 8'h51}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk);
    eng_tx_pop = 1'b1;
    #1 d = eng_tx_byte;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_byte = b;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic start(input logic [7:0] ctl);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CT; reg_wdata = ctl;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    eng_tx_pop = 1'b0; eng_rx_push = 1'b0; eng_rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_ST, v); check("R1 status", v, 8'h00);
    rd(A_CT, v); check("R1 ctrl", v, 8'h00);
    rd(A_AX, v); check("R1 aux", v, 8'h00);
    rd(A_D0, v); check("R1 data0", v, 8'h00);
    check("R1 eng_go", {7'd0, eng_go}, 8'h00);
    check("R1 eng_hold", {7'd0, eng_hold}, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) begin
        rd(VEC[i][18:16], v);
        check($sformatf("R%0d row %0d", VEC[i][23:20], i), v, VEC[i][7:0]);
      end else begin
        wr(VEC[i][18:16], VEC[i][15:8]);
      end
    end

    // R4 fill beyond depth
    rd(A_CT, v);
    for (int i = 0; i < 32; i++) wr(A_BK, 8'(i + 1));
    wr(A_BK, 8'hEE);
    rd(A_CT, v);
    for (int i = 0; i < 32; i++) begin
      rd(A_BK, v); check($sformatf("R4 entry %0d", i), v, 8'(i + 1));
    end
    rd(A_BK, v); check("R4 read past end", v, 8'h00);

    // R11 start pulse, R3 engine pops from entry 0
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CT; reg_wdata = 8'h40;
    @(negedge clk);
    reg_wr = 1'b0;
    #1 check("R11 go high", {7'd0, eng_go}, 8'h01);
    @(negedge clk);
    #1 check("R11 go low", {7'd0, eng_go}, 8'h00);
    rd(A_CT, v); check("R11 start not stored", v, 8'h00);
    pop(v); check("R3 pop0", v, 8'h01);
    pop(v); check("R3 pop1", v, 8'h02);
    pop(v); check("R3 pop2", v, 8'h03);

    // R5 SMBus block read, count 3 then an extra byte
    wr(A_AD, 8'h51);
    start(8'h41);
    push(8'h03); push(8'hA1); push(8'hB2); push(8'hC3); push(8'hD4);
    rd(A_D0, v); check("R5 count in data0", v, 8'h03);
    check("R5 eng_len", eng_len, 8'h03);
    rd(A_ST, v); check("R5 no error", v, 8'h00);
    rd(A_CT, v); check("R5 ctrl kind", v, 8'h01);
    rd(A_BK, v); check("R5 e0", v, 8'hA1);
    rd(A_BK, v); check("R5 e1", v, 8'hB2);
    rd(A_BK, v); check("R5 e2", v, 8'hC3);
    rd(A_BK, v); check("R5 extra dropped", v, 8'h04);

    // R6 count range
    start(8'h41);
    push(8'h00);
    rd(A_ST, v); check("R6 zero count flag", v, 8'h08);
    push(8'h77);
    wr(A_ST, 8'h08);
    rd(A_ST, v); check("R6 flag cleared", v, 8'h00);
    rd(A_CT, v);
    rd(A_BK, v); check("R6 zero count stores nothing", v, 8'hA1);
    start(8'h41);
    push(8'h21);
    rd(A_ST, v); check("R6 count 33 flag", v, 8'h08);
    wr(A_ST, 8'h08);
    start(8'h41);
    push(8'h01); push(8'h99); push(8'h98);
    rd(A_ST, v); check("R6 count 1 ok", v, 8'h00);
    rd(A_CT, v);
    rd(A_BK, v); check("R5 count 1 e0", v, 8'h99);
    rd(A_BK, v); check("R5 count 1 e1 kept", v, 8'hB2);

    // R9 address and command selection
    check("R9 smb addr", eng_addr_byte, 8'h51);
    check("R9 smb cmd", eng_cmd_byte, 8'h3C);
    wr(A_CT, 8'h02);
    check("R9 i2c read addr", eng_addr_byte, 8'h50);
    check("R9 i2c read cmd", eng_cmd_byte, 8'hA5);
    wr(A_AD, 8'h50);
    check("R9 i2c write cmd", eng_cmd_byte, 8'h3C);

    // R10 last-byte NACK
    wr(A_CT, 8'h06); wr(A_AD, 8'h51);
    check("R10 nack on read", {7'd0, eng_nack_last}, 8'h01);
    wr(A_AD, 8'h50);
    check("R10 no nack on write", {7'd0, eng_nack_last}, 8'h00);
    wr(A_CT, 8'h02); wr(A_AD, 8'h51);
    check("R10 no nack without last", {7'd0, eng_nack_last}, 8'h00);

    // R7 R8 byte-by-byte mode
    wr(A_AX, 8'h00);
    wr(A_BK, 8'h5A);
    rd(A_BK, v); check("R7 hold byte", v, 8'h5A);
    rd(A_BK, v); check("R7 hold byte no advance", v, 8'h5A);
    pop(v); check("R7 tx from hold", v, 8'h5A);
    check("R7 hold after tx", {7'd0, eng_hold}, 8'h01);
    rd(A_ST, v); check("R7 done flag", v, 8'h80);
    wr(A_ST, 8'h00);
    check("R8 zero write keeps hold", {7'd0, eng_hold}, 8'h01);
    wr(A_ST, 8'h80);
    check("R8 release", {7'd0, eng_hold}, 8'h00);
    rd(A_ST, v); check("R8 flag cleared", v, 8'h00);
    start(8'h42);
    push(8'h6B);
    rd(A_BK, v); check("R7 rx byte", v, 8'h6B);
    check("R7 hold after rx", {7'd0, eng_hold}, 8'h01);
    wr(A_ST, 8'h80);
    start(8'h41);
    push(8'h02);
    rd(A_D0, v); check("R7 count to data0", v, 8'h02);
    check("R7 count sets no hold", {7'd0, eng_hold}, 8'h00);
    push(8'h7C);
    check("R7 data sets hold", {7'd0, eng_hold}, 8'h01);
    rd(A_BK, v); check("R7 data byte", v, 8'h7C);
    wr(A_ST, 8'h80);
    wr(A_AX, 8'h02);
    rd(A_CT, v);
    rd(A_BK, v); check("R7 buffer untouched", v, 8'h99);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule